// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Receive Queue

This block takes in 8-bit frames from a clock-synchronous serial link and queues each completed byte in a 16-entry receive FIFO. The link has a serial clock and a serial data line, and a frame has no start or stop bits. Both lines are brought into the system clock domain through two-flop synchronizers. A data bit is taken on each detected rising edge of the serial clock. The first bit received becomes bit 0 of the byte.

Software reaches the block through a small register port with three registers: control, flags and data. Reading the data register removes the oldest byte from the queue. The block raises a fill flag once a programmable number of bytes is waiting. If a frame completes while the queue is full, the block declares an overrun and stops receiving until software clears the overrun flag. Two interrupt lines leave the block: one for data waiting and one for errors.

Top module: `srx_top`

## Requirements
- R1: A received byte is assembled least significant bit first: the first bit sampled becomes bit 0 and the eighth becomes bit 7.
- R2: Each bit is sampled on a synchronized rising edge of `ser_clk`. The eighth such edge completes a frame, and the byte is appended to the queue a few system cycles later.
- R3: The queue holds up to 16 bytes and returns them oldest first. Each read of address 2 returns the head and removes it. A read of address 2 while the queue is empty returns 0 and removes nothing.
- R4: A frame that completes while the queue holds 16 bytes sets the overrun flag (address 1, bit 1). That frame's byte is discarded and the queue is left as it was.
- R5: While the overrun flag is 1, serial clock edges are ignored and no byte is queued. Writing a 0 to bit 1 of address 1 clears the flag, and reception resumes with a fresh frame.
- R6: The fill flag (address 1, bit 0) is set in every cycle in which the queue count is at least the trigger level. The trigger level is control bits 7:4 plus one. Writing a 0 to bit 0 of address 1 clears the flag for that cycle only; it is set again on the next cycle if the count is still at or above the trigger level.
- R7: `irq_data` is 1 exactly when the fill flag is 1 and the data interrupt enable (control bit 1) is 1.
- R8: `irq_err` is 1 exactly when the overrun flag is 1 and at least one of control bit 1 or the error interrupt enable (control bit 2) is 1. An overrun by itself never drives `irq_data`.
- R9: Control bit 0 enables reception. While it is 0 the bit count is held at zero, so a partly received frame is discarded.
- R10: Writing a 1 to a flag bit at address 1 leaves that flag unchanged. After reset, the control register, both flags and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the link, asynchronous |
| ser_data | input | 1 | Serial data from the link, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the queue at address 2) |
| reg_addr | input | 2 | Register select: 0 control, 1 flags, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected address |
| irq_data | output | 1 | Data-waiting interrupt request |
| irq_err | output | 1 | Overrun/error interrupt request |

## Verification
The in-line assertions check four things on every cycle. The queue count never exceeds its depth and no byte is appended to a full queue. The overrun flag rises only when a frame completes against a full queue, and once set it stays set until a clearing write arrives. No frame completes while reception is blocked, and the bit counter sits at zero whenever reception is disabled. The bench scenarios cover the rest, which depends on the order of events. They show bit order, oldest-first readout, the trigger threshold and how the fill flag sets again after a clear. They also show that a partial frame is dropped when reception is disabled, that the overrun byte and every later byte are discarded, that writing a 1 to a flag changes nothing, and that reception resumes cleanly once the overrun flag is cleared.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned FIFO_DEPTH = 16;
    localparam int unsigned TRIG_W     = 4;
    localparam int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1);

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_FLAG = 2'd1,
        REG_DATA = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [TRIG_W-1:0] trig;
        logic              spare;
        logic              err_ie;
        logic              dat_ie;
        logic              rx_en;
    } ctrl_t;

    typedef struct packed {
        logic [5:0] zero;
        logic       ovr;
        logic       fill;
    } flag_t;

    function automatic logic [CNT_W-1:0] trig_level(input logic [TRIG_W-1:0] f);
        return CNT_W'(f) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_clk,
    input  logic         ser_data,
    input  logic         rx_en,
    input  logic         blocked,
    output logic         frame_done,
    output logic [W-1:0] frame_byte
);
    localparam int unsigned BC_W = $clog2(W);

    logic [2:0]      ck_q;
    logic [1:0]      dt_q;
    logic [BC_W-1:0] bit_cnt;
    logic [W-1:0]    shreg;
    logic            rise;
    logic [W-1:0]    shifted;

    assign rise    = ck_q[1] & ~ck_q[2];
    assign shifted = {dt_q[1], shreg[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_q <= '0;
            dt_q <= '0;
        end else begin
            ck_q <= {ck_q[1:0], ser_clk};
            dt_q <= {dt_q[0], ser_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            frame_done <= 1'b0;
            frame_byte <= '0;
        end else begin
            frame_done <= 1'b0;
            if (!rx_en) begin
                bit_cnt <= '0;
            end else if (rise && !blocked) begin
                shreg <= shifted;
                if (bit_cnt == BC_W'(W - 1)) begin
                    bit_cnt    <= '0;
                    frame_done <= 1'b1;
                    frame_byte <= shifted;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    a_r5_blocked_no_frame: assert property (@(posedge clk) disable iff (rst)
        blocked |=> !frame_done);
    a_r9_disable_clears_count: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (bit_cnt == '0));

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned DEPTH = FIFO_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    a_r4_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    a_r3_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/srx_regs.sv
module srx_regs
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              frame_done,
    input  logic [CNT_W-1:0]  q_count,
    input  logic              q_full,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_head,
    output logic              q_push,
    output logic              q_pop,
    output logic              rx_en,
    output logic              blocked,
    output logic              irq_data,
    output logic              irq_err
);
    ctrl_t    ctrl;
    flag_t    wr_flag;
    flag_t    rd_flag;
    reg_sel_e sel;
    logic     fill;
    logic     ovr;
    logic     flag_wr;
    logic     fill_clr;
    logic     ovr_clr;

    assign sel      = reg_sel_e'(reg_addr);
    assign wr_flag  = flag_t'(reg_wdata);
    assign flag_wr  = reg_wr && (sel == REG_FLAG);
    assign fill_clr = flag_wr && !wr_flag.fill;
    assign ovr_clr  = flag_wr && !wr_flag.ovr;

    assign q_push  = frame_done && !q_full;
    assign q_pop   = reg_rd && (sel == REG_DATA) && !q_empty;
    assign rx_en   = ctrl.rx_en;
    assign blocked = ovr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (reg_wr && (sel == REG_CTRL)) begin
            ctrl <= ctrl_t'(reg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            if (fill_clr)                              fill <= 1'b0;
            else if (q_count >= trig_level(ctrl.trig)) fill <= 1'b1;

            if (ovr_clr)                      ovr <= 1'b0;
            else if (frame_done && q_full)    ovr <= 1'b1;
        end
    end

    always_comb begin
        rd_flag      = '0;
        rd_flag.fill = fill;
        rd_flag.ovr  = ovr;
        case (sel)
            REG_CTRL: reg_rdata = ctrl;
            REG_FLAG: reg_rdata = rd_flag;
            REG_DATA: reg_rdata = q_empty ? '0 : q_head;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_data = fill && ctrl.dat_ie;
    assign irq_err  = ovr && (ctrl.dat_ie || ctrl.err_ie);

    a_r4_overrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(frame_done && q_full));
    a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);
    a_r6_fill_needs_level: assert property (@(posedge clk) disable iff (rst)
        $rose(fill) |-> $past(q_count >= trig_level(ctrl.trig)));

endmodule

// File: rtl/srx_top.sv
module srx_top
    import srx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_clk,
    input  logic       ser_data,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_data,
    output logic       irq_err
);
    logic              frame_done;
    logic [DATA_W-1:0] frame_byte;
    logic              rx_en;
    logic              blocked;
    logic              q_push;
    logic              q_pop;
    logic [DATA_W-1:0] q_head;
    logic [CNT_W-1:0]  q_count;
    logic              q_full;
    logic              q_empty;

    srx_sampler #(.W(DATA_W)) u_sampler (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .rx_en(rx_en), .blocked(blocked),
        .frame_done(frame_done), .frame_byte(frame_byte)
    );

    srx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(q_push), .push_data(frame_byte),
        .pop(q_pop), .head(q_head), .count(q_count),
        .full(q_full), .empty(q_empty)
    );

    srx_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frame_done(frame_done), .q_count(q_count), .q_full(q_full),
        .q_empty(q_empty), .q_head(q_head), .q_push(q_push), .q_pop(q_pop),
        .rx_en(rx_en), .blocked(blocked),
        .irq_data(irq_data), .irq_err(irq_err)
    );

endmodule

// File: tb/srx_top_tb.sv
module srx_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_data;
    logic       irq_err;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h01, 8'h80, 8'hA5, 8'h5A, 8'hFF, 8'h00};

    always #5 clk = ~clk;

    srx_top u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_data(irq_data), .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_data = b; ser_clk = 1'b0;
        idle(4);
        ser_clk = 1'b1;
        idle(4);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
        ser_clk = 1'b0;
        idle(6);
    endtask

    initial begin
        logic [7:0] d;
        idle(3);
        rst = 1'b0;
        idle(2);

        // Reset state (R10, R3)
        rd(2'd0, d); check("R10 ctrl after reset", d, 8'h00);
        rd(2'd1, d); check("R10 flags after reset", d, 8'h00);
        check("R10 irq_data after reset", {7'd0, irq_data}, 8'h00);
        check("R10 irq_err after reset", {7'd0, irq_err}, 8'h00);
        rd(2'd2, d); check("R3 empty read", d, 8'h00);

        // Vector table: trigger level 1, data irq enabled
        wr(2'd0, 8'h03);
        for (int k = 0; k < NVEC; k++) begin
            send_byte(VEC[k]);
            rd(2'd1, d); check("R6 fill at level 1", d, 8'h01);
            check("R7 irq_data with enable", {7'd0, irq_data}, 8'h01);
            rd(2'd2, d); check("R1 R2 byte value", d, VEC[k]);
            wr(2'd1, 8'h02);
            rd(2'd1, d); check("R6 fill cleared", d, 8'h00);
            check("R7 irq_data cleared", {7'd0, irq_data}, 8'h00);
        end

        // Trigger level 4 (field 3)
        wr(2'd0, 8'h33);
        for (int k = 0; k < 3; k++) send_byte(8'h10 + 8'(k));
        rd(2'd1, d); check("R6 below trigger", d, 8'h00);
        send_byte(8'h13);
        rd(2'd1, d); check("R6 at trigger", d, 8'h01);
        wr(2'd1, 8'h00);
        idle(2);
        rd(2'd1, d); check("R6 fill sets again", d, 8'h01);
        for (int k = 0; k < 4; k++) begin
            rd(2'd2, d); check("R3 oldest first", d, 8'h10 + 8'(k));
        end
        wr(2'd1, 8'h00);
        idle(2);
        rd(2'd1, d); check("R6 stays clear when drained", d, 8'h00);

        // Partial frame discard (R9)
        wr(2'd0, 8'h01);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        ser_clk = 1'b0;
        wr(2'd0, 8'h00);
        wr(2'd0, 8'h01);
        send_byte(8'hA5);
        rd(2'd2, d); check("R9 partial frame dropped", d, 8'hA5);
        rd(2'd2, d); check("R3 empty after drain", d, 8'h00);

        // Overrun (R4, R5, R8, R10)
        for (int k = 0; k < 16; k++) send_byte(8'(k));
        rd(2'd1, d); check("R4 full, no overrun yet", d, 8'h01);
        send_byte(8'hEE);
        rd(2'd1, d); check("R4 overrun set", d, 8'h03);
        check("R8 irq_err no enables", {7'd0, irq_err}, 8'h00);
        wr(2'd0, 8'h05);
        check("R8 irq_err with err enable", {7'd0, irq_err}, 8'h01);
        check("R8 no irq_data from overrun", {7'd0, irq_data}, 8'h00);
        wr(2'd0, 8'h03);
        check("R8 irq_err with data enable", {7'd0, irq_err}, 8'h01);
        wr(2'd1, 8'hFF);
        rd(2'd1, d); check("R10 write one keeps flags", d, 8'h03);
        rd(2'd2, d); check("R4 head unchanged", d, 8'h00);
        send_byte(8'h77);
        rd(2'd1, d); check("R5 still blocked", d, 8'h03);
        for (int k = 1; k < 16; k++) begin
            rd(2'd2, d); check("R5 R4 queued bytes intact", d, 8'(k));
        end
        rd(2'd2, d); check("R5 nothing extra queued", d, 8'h00);
        wr(2'd1, 8'h00);
        rd(2'd1, d); check("R5 overrun cleared", d, 8'h00);
        check("R8 irq_err cleared", {7'd0, irq_err}, 8'h00);
        send_byte(8'h3C);
        rd(2'd2, d); check("R5 reception resumes", d, 8'h3C);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule